// File: doc/BRIEF.md
# Memory Hole Remap Translator

This block turns a memory-controller page number (4 KiB units) into a system physical page number. Firmware moves the addresses under a low-memory hole, such as an I/O aperture, to a window above the 4 GiB line. The controller still sees those pages packed straight after the top of low memory, so each page it reports has to be mapped to its system location. Three 16-bit configuration values set up the mapping:

- a top-of-low-memory count, scaled by 16 pages;
- a remap window base, scaled by 16384 pages;
- a remap window limit, scaled by 16384 pages.

A small write port loads these values. Decoding the configuration interface upstream is out of scope.

Page numbers enter on a valid/ready stream and the result leaves on a second valid/ready stream, one cycle later. A transfer happens on a clock edge where valid and ready are both high. The output stage holds a single result. While that result is valid and `out_ready` is low, the result stays frozen and `in_ready` is low, so back-pressure passes straight through to the producer. When `out_ready` is high, a new page can be accepted on the same edge that the old result leaves.

Pages that fall in no window come back flagged, with a fixed fallback page.

Top module: `hole_remap_xlate`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and all three configuration values are 0. With these values every page is out of range and yields page 0xFFFFFF with the error flag set.
- R2: A write with `cfg_we`=1 loads `cfg_data` into one configuration value, chosen by `cfg_sel`: 0 selects top-of-low-memory, 1 selects remap base, 2 selects remap limit. A write with `cfg_sel`=3 changes nothing.
- R3: The top-of-low-memory page count is the value shifted left by 4. The base and limit pages are their values shifted left by 14, truncated to 24 bits.
- R4: A page strictly below the top-of-low-memory count is returned unchanged with the error flag clear.
- R5: A page at or above 0x100000 and strictly below the remap base page is returned unchanged with the error flag clear.
- R6: Any other page maps to (page − top-of-low-memory) + remap base, computed unsigned modulo 2^24. When that sum is strictly below the remap limit page, it is the output and the error flag is clear.
- R7: When the mapped sum in R6 is at or above the limit page, the error flag is set and the output page is top-of-low-memory − 1, modulo 2^24.
- R8: A page accepted on one edge appears on `out_page`/`out_err` with `out_valid`=1 after the next edge.
- R9: While `out_valid`=1 and `out_ready`=0, the output holds its page and flag, `out_valid` stays 1, and `in_ready` is 0. A page offered during the stall is delivered once the stall ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration value select |
| cfg_data | input | 16 | Configuration write data |
| in_valid | input | 1 | Input page valid |
| in_ready | output | 1 | Block can accept a page |
| in_page | input | 24 | Controller page number |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_page | output | 24 | System page number |
| out_err | output | 1 | Page falls outside every window |

## Verification
The bench runs three configurations:

- A remap base at exactly 0x100000, which leaves the upper pass-through window empty.
- A base above 0x100000, which opens that window.
- A base value large enough that its shifted form is truncated to 24 bits.

For each configuration it sends a strided sweep of 4096 pages spread over the whole 24-bit space, plus the page on each side of every boundary:

- top-of-low-memory,
- 0x100000,
- the base,
- the last mapped page,
- zero,
- the all-ones page.

These boundary pairs separate strict from inclusive comparisons, and the sweeps show that every region is routed correctly.

A further test holds `out_ready` low while a second page waits, to check the hold and the hand-over. A write with the unused select is followed by a translation, to show that no value moved.

// File: rtl/hole_remap_pkg.sv
package hole_remap_pkg;
  typedef enum logic [1:0] {
    CFG_TOP_LOW  = 2'd0,
    CFG_WIN_BASE = 2'd1,
    CFG_WIN_LIM  = 2'd2,
    CFG_UNUSED   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/hole_cfg_regs.sv
module hole_cfg_regs
  import hole_remap_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] top_raw,
  output logic [CFG_W-1:0] base_raw,
  output logic [CFG_W-1:0] lim_raw
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_raw  <= '0;
      base_raw <= '0;
      lim_raw  <= '0;
    end else if (wr_en) begin
      case (sel)
        CFG_TOP_LOW:  top_raw  <= wr_data;
        CFG_WIN_BASE: base_raw <= wr_data;
        CFG_WIN_LIM:  lim_raw  <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hole_xlate_core.sv
module hole_xlate_core #(
  parameter int PAGE_W    = 24,
  parameter int CFG_W     = 16,
  parameter int TOP_SHIFT = 4,
  parameter int WIN_SHIFT = 14,
  parameter logic [PAGE_W-1:0] HIGH_START = 24'h100000
) (
  input  logic [CFG_W-1:0]  top_raw,
  input  logic [CFG_W-1:0]  base_raw,
  input  logic [CFG_W-1:0]  lim_raw,
  input  logic [PAGE_W-1:0] page_in,
  output logic [PAGE_W-1:0] page_out,
  output logic              err_out
);
  localparam int MAX_SH = (WIN_SHIFT > TOP_SHIFT) ? WIN_SHIFT : TOP_SHIFT;
  localparam int EXT_W  = PAGE_W + CFG_W + MAX_SH;

  logic [EXT_W-1:0]  top_ext, base_ext, lim_ext;
  logic [PAGE_W-1:0] top_pg, base_pg, lim_pg, moved;
  logic              in_low, in_high, fits;

  assign top_ext  = EXT_W'(top_raw)  << TOP_SHIFT;
  assign base_ext = EXT_W'(base_raw) << WIN_SHIFT;
  assign lim_ext  = EXT_W'(lim_raw)  << WIN_SHIFT;
  assign top_pg   = top_ext[PAGE_W-1:0];
  assign base_pg  = base_ext[PAGE_W-1:0];
  assign lim_pg   = lim_ext[PAGE_W-1:0];

  assign in_low  = page_in < top_pg;
  assign in_high = (page_in >= HIGH_START) && (page_in < base_pg);
  assign moved   = (page_in - top_pg) + base_pg;
  assign fits    = moved < lim_pg;

  always_comb begin
    err_out  = 1'b0;
    page_out = page_in;
    if (!(in_low || in_high)) begin
      if (fits) begin
        page_out = moved;
      end else begin
        page_out = top_pg - PAGE_W'(1);
        err_out  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hole_out_stage.sv
module hole_out_stage #(
  parameter int DATA_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_valid && up_ready) begin
      dn_valid <= 1'b1;
      dn_data  <= up_data;
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hole_remap_xlate.sv
module hole_remap_xlate #(
  parameter int PAGE_W    = 24,
  parameter int CFG_W     = 16,
  parameter int TOP_SHIFT = 4,
  parameter int WIN_SHIFT = 14,
  parameter logic [PAGE_W-1:0] HIGH_START = 24'h100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PAGE_W-1:0] in_page,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PAGE_W-1:0] out_page,
  output logic              out_err
);
  localparam int RES_W = PAGE_W + 1;

  logic [CFG_W-1:0]  top_raw, base_raw, lim_raw;
  logic [PAGE_W-1:0] xl_page;
  logic              xl_err;
  logic [RES_W-1:0]  res_out;

  hole_cfg_regs #(.CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_data(cfg_data), .top_raw(top_raw), .base_raw(base_raw),
    .lim_raw(lim_raw)
  );

  hole_xlate_core #(
    .PAGE_W(PAGE_W), .CFG_W(CFG_W), .TOP_SHIFT(TOP_SHIFT),
    .WIN_SHIFT(WIN_SHIFT), .HIGH_START(HIGH_START)
  ) u_core (
    .top_raw(top_raw), .base_raw(base_raw), .lim_raw(lim_raw),
    .page_in(in_page), .page_out(xl_page), .err_out(xl_err)
  );

  hole_out_stage #(.DATA_W(RES_W)) u_out (
    .clk(clk), .rst_n(rst_n), .up_valid(in_valid), .up_ready(in_ready),
    .up_data({xl_err, xl_page}), .dn_valid(out_valid),
    .dn_ready(out_ready), .dn_data(res_out)
  );

  assign out_err  = res_out[PAGE_W];
  assign out_page = res_out[PAGE_W-1:0];
endmodule

// File: rtl/hole_remap_chk.sv
module hole_remap_chk #(
  parameter int PAGE_W    = 24,
  parameter int CFG_W     = 16,
  parameter int TOP_SHIFT = 4,
  parameter int WIN_SHIFT = 14,
  parameter logic [PAGE_W-1:0] HIGH_START = 24'h100000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [PAGE_W-1:0] in_page,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PAGE_W-1:0] out_page,
  input logic              out_err,
  input logic [CFG_W-1:0]  top_raw,
  input logic [CFG_W-1:0]  base_raw
);
  localparam int EXT_W = PAGE_W + CFG_W + WIN_SHIFT + TOP_SHIFT;
  logic [EXT_W-1:0]  t_ext, b_ext;
  logic [PAGE_W-1:0] t_pg, b_pg;
  logic              take;
  assign t_ext = EXT_W'(top_raw)  << TOP_SHIFT;
  assign b_ext = EXT_W'(base_raw) << WIN_SHIFT;
  assign t_pg  = t_ext[PAGE_W-1:0];
  assign b_pg  = b_ext[PAGE_W-1:0];
  assign take  = in_valid && in_ready;

  // R8
  a_r8_accept_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R9
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_page) && $stable(out_err)));

  // R4
  a_r4_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_page < t_pg) |=> (!out_err && out_page == $past(in_page)));

  // R5
  a_r5_high_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_page >= HIGH_START && in_page < b_pg) |=> (!out_err && out_page == $past(in_page)));
endmodule

bind hole_remap_xlate hole_remap_chk #(
  .PAGE_W(PAGE_W), .CFG_W(CFG_W), .TOP_SHIFT(TOP_SHIFT),
  .WIN_SHIFT(WIN_SHIFT), .HIGH_START(HIGH_START)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_page(in_page), .out_valid(out_valid), .out_ready(out_ready),
  .out_page(out_page), .out_err(out_err), .top_raw(top_raw),
  .base_raw(base_raw)
);

// File: tb/tb_hole_remap_xlate.sv
module tb_hole_remap_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_page = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_page;
  logic        out_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [15:0] m_top, m_base, m_lim;

  always #5 clk = ~clk;

  hole_remap_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_page(in_page), .out_valid(out_valid), .out_ready(out_ready),
    .out_page(out_page), .out_err(out_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result per requirements R3..R7, with a region tag
  function automatic logic [24:0] model(input logic [23:0] p, output string tag);
    logic [23:0] t, b, l, mv;
    t = {4'h0, m_top, 4'h0};
    b = {m_base[9:0], 14'h0};
    l = {m_lim[9:0], 14'h0};
    if (p < t) begin tag = "R4"; return {1'b0, p}; end
    if (p >= 24'h100000 && p < b) begin tag = "R5"; return {1'b0, p}; end
    mv = p - t + b;
    if (mv < l) begin tag = "R6"; return {1'b0, mv}; end
    tag = "R7";
    return {1'b1, t - 24'd1};
  endfunction

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s == 2'd0) m_top = d;
    else if (s == 2'd1) m_base = d;
    else if (s == 2'd2) m_lim = d;
  endtask

  task automatic send(input logic [23:0] p);
    logic [24:0] e;
    string tag;
    e = model(p, tag);
    @(negedge clk);
    in_valid = 1'b1; in_page = p; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({"R8 valid ", tag}, {31'd0, out_valid}, 32'd1);
    chk({tag, " page+err"}, {7'd0, out_err, out_page}, {7'd0, e});
  endtask

  task automatic run_cfg(input logic [15:0] t, input logic [15:0] b, input logic [15:0] l);
    logic [23:0] tp, bp, lp;
    wr(2'd0, t); wr(2'd1, b); wr(2'd2, l);
    tp = {4'h0, t, 4'h0}; bp = {b[9:0], 14'h0}; lp = {l[9:0], 14'h0};
    send(tp - 1); send(tp); send(24'h0FFFFF); send(24'h100000);
    send(bp - 1); send(bp); send(24'h0); send(24'hFFFFFF);
    send(lp - bp + tp - 1); send(lp - bp + tp);
    for (int k = 0; k < 4096; k++) send(24'(k << 12) | 24'((k * 37) & 12'hFFF));
  endtask

  initial begin
    m_top = '0; m_base = '0; m_lim = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
    chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    send(24'h000005);
    chk("R1 zero config page", {8'd0, out_page}, 32'h00FFFFFF);
    chk("R1 zero config err", {31'd0, out_err}, 32'd1);

    // base exactly at 4 GiB: empty upper pass window
    run_cfg(16'hE000, 16'h0040, 16'h0048);
    // R2: unused select must change nothing
    wr(2'd3, 16'h1234);
    send(24'h0DFFFF);
    chk("R2 unused select keeps top", {8'd0, out_page}, 32'h000DFFFF);
    send(24'h0E0000);
    chk("R2 unused select keeps base", {8'd0, out_page}, 32'h00100000);
    // base above 4 GiB: open upper pass window
    run_cfg(16'hC000, 16'h0050, 16'h0058);
    // R3: base/limit truncated to 24 bits after shift
    run_cfg(16'hA000, 16'h07F0, 16'h07FC);

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_page = 24'h000123;
    @(negedge clk);
    in_page = 24'h000456;
    chk("R9 first result valid", {31'd0, out_valid}, 32'd1);
    chk("R9 in_ready low in stall", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R9 held page", {8'd0, out_page}, 32'h00000123);
    chk("R9 still valid", {31'd0, out_valid}, 32'd1);
    chk("R9 in_ready still low", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 waiting page delivered", {8'd0, out_page}, 32'h00000456);
    chk("R9 valid after handover", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R9 drained", {31'd0, out_valid}, 32'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule